// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block lengthens external memory read and write cycles by adding wait states. When a cycle starts, the block takes the target area's programmed wait count, from 0 to 7. One count setting serves each pair of address areas, and the surrounding bus logic supplies the right value. The block serves that count first.

An active-low external wait input can stretch the cycle further. The input passes through a two-stage synchronizer clocked on the falling bus-clock edge. An enable bit gates the input. A cold reset clears this enable bit, and a hot reset keeps it.

The wait input is honoured only for SRAM-type areas and for write cycles to burst-ROM areas. Burst-ROM reads and all other area types use the programmed count alone. While a cycle is in progress the block drives a stall output high. It ends the cycle with a one-clock done pulse.

Top module: `extWaitCtl`

## Requirements
- R1: After a cold reset, `stall`, `cycDone` and `waitEnOut` are all 0.
- R2: When `cfgWr` is high at a rising edge, `waitEnOut` takes the value of `cfgWaitEnIn` from the next cycle on. Otherwise `waitEnOut` does not change. A hot reset leaves `waitEnOut` unchanged.
- R3: A start with programmed count N (0..7) and no wait from the pin holds `stall` high for exactly N+1 clocks, counted from the edge that accepts `cycStart`.
- R4: `cycDone` is high for exactly one clock, in the cycle right after `stall` falls. `stall` and `cycDone` are never high together.
- R5: For SRAM areas (`areaType` = 2'b01) with the enable bit set at start, a low `waitPinN` extends the cycle. Each sample is taken on a falling edge and passes through two falling-edge flops. The cycle ends at the first rising edge where the count is exhausted and the synchronized sample is high. If the pin is released right after the rising edge `rel` clocks after the accepting edge, `stall` lasts max(N+1, rel+2) clocks.
- R6: For burst-ROM areas (`areaType` = 2'b10), the pin extends write cycles (`isWrite` = 1) as in R5. Read cycles ignore the pin.
- R7: For other area types (`areaType` = 2'b00 or 2'b11), the pin is ignored and the cycle lasts N+1 clocks.
- R8: When the enable bit is 0 at the start, the pin is ignored for every area type.
- R9: A `cycStart` that arrives while `stall` is high is ignored. It does not change the running cycle's length and does not start a second cycle.
- R10: A hot reset aborts a cycle in progress: `stall` and `cycDone` go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| coldRstN | input | 1 | Cold reset, active low, asynchronous; clears everything |
| hotRstN | input | 1 | Hot reset, active low, asynchronous; keeps the enable bit |
| cfgWr | input | 1 | Write strobe for the wait-pin enable bit |
| cfgWaitEnIn | input | 1 | New value for the enable bit |
| waitEnOut | output | 1 | Stored enable bit |
| cycStart | input | 1 | Cycle start strobe |
| areaType | input | 2 | Area kind: 01 SRAM, 10 burst ROM, 00/11 other |
| isWrite | input | 1 | 1 for a write cycle, 0 for a read cycle |
| waitCnt | input | 3 | Programmed wait count for the target area |
| waitPinN | input | 1 | External wait request, active low |
| stall | output | 1 | High while a cycle is in progress |
| cycDone | output | 1 | One-clock pulse at cycle end |

## Verification
`stall` rises one edge after a start is accepted. `cycDone` rises on the edge where `stall` falls. A pin release made just after rising edge `rel` becomes visible at edge `rel+2`, after two falling-edge flops. The enable bit reads back one edge after the write.

The bench drives every input one time unit after a rising edge. A behavioural model advances on each rising edge and keeps its own queue of falling-edge pin samples. The outputs are compared four time units after each rising edge, once the registers have settled.

Directed runs also count clocks from the accepting edge up to the done pulse. They check that count against N+1 or max(N+1, rel+2), depending on the area type, direction and enable bit.

// File: rtl/extWaitPkg.sv
package extWaitPkg;

  typedef enum logic [1:0] {
    AREA_OTHER_A = 2'b00,
    AREA_SRAM    = 2'b01,
    AREA_BROM    = 2'b10,
    AREA_OTHER_B = 2'b11
  } areaKindT;

  typedef struct packed {
    logic load;    // accept a new cycle: capture count and pin policy
    logic dec;     // one programmed wait cycle consumed
    logic finish;  // cycle ends at this edge
  } ctlStrobeT;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } ctlStateT;

endpackage

// File: rtl/extWaitSync.sv
module extWaitSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(negedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b1;
          else       chain[0] <= dIn;
        end
      end else begin : g_next
        always_ff @(negedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= 1'b1;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dOut = chain[STAGES-1];
endmodule

// File: rtl/extWaitData.sv
module extWaitData
  import extWaitPkg::*;
#(
  parameter int CNT_W       = 3,
  parameter int AREA_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              coldRstN,
  input  logic              ctlRstN,
  input  logic              cfgWr,
  input  logic              cfgWaitEnIn,
  input  logic [AREA_W-1:0] areaType,
  input  logic              isWrite,
  input  logic [CNT_W-1:0]  waitCnt,
  input  logic              waitPinN,
  input  ctlStrobeT         strobes,
  output logic              cntZero,
  output logic              pinHold,
  output logic              waitEn
);
  logic [CNT_W-1:0] cntQ;
  logic             pinUseQ;
  logic             pinSync;
  logic             pinApplies;

  // Enable bit: only a cold reset clears it.
  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN)  waitEn <= 1'b0;
    else if (cfgWr) waitEn <= cfgWaitEnIn;
  end

  always_comb begin
    unique case (areaKindT'(areaType[1:0]))
      AREA_SRAM: pinApplies = 1'b1;
      AREA_BROM: pinApplies = isWrite;
      default:   pinApplies = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge ctlRstN) begin
    if (!ctlRstN) begin
      cntQ    <= '0;
      pinUseQ <= 1'b0;
    end else if (strobes.load) begin
      cntQ    <= waitCnt;
      pinUseQ <= waitEn & pinApplies;
    end else begin
      if (strobes.dec)    cntQ    <= cntQ - 1'b1;
      if (strobes.finish) pinUseQ <= 1'b0;
    end
  end

  extWaitSync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(ctlRstN),
    .dIn (waitPinN),
    .dOut(pinSync)
  );

  assign cntZero = (cntQ == '0);
  assign pinHold = pinUseQ & ~pinSync;
endmodule

// File: rtl/extWaitCtrl.sv
module extWaitCtrl
  import extWaitPkg::*;
(
  input  logic      clk,
  input  logic      ctlRstN,
  input  logic      cycStart,
  input  logic      cntZero,
  input  logic      pinHold,
  output ctlStrobeT strobes,
  output logic      stall,
  output logic      cycDone
);
  ctlStateT stateQ;
  ctlStateT stateD;

  always_comb begin
    strobes        = '0;
    stateD         = stateQ;
    if (stateQ == ST_IDLE) begin
      if (cycStart) begin
        strobes.load = 1'b1;
        stateD       = ST_BUSY;
      end
    end else begin
      if (!cntZero) begin
        strobes.dec = 1'b1;
      end else if (!pinHold) begin
        strobes.finish = 1'b1;
        stateD         = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge ctlRstN) begin
    if (!ctlRstN) begin
      stateQ  <= ST_IDLE;
      cycDone <= 1'b0;
    end else begin
      stateQ  <= stateD;
      cycDone <= strobes.finish;
    end
  end

  assign stall = (stateQ == ST_BUSY);
endmodule

// File: rtl/extWaitCtl.sv
module extWaitCtl
  import extWaitPkg::*;
#(
  parameter int CNT_W       = 3,
  parameter int AREA_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              coldRstN,
  input  logic              hotRstN,
  input  logic              cfgWr,
  input  logic              cfgWaitEnIn,
  output logic              waitEnOut,
  input  logic              cycStart,
  input  logic [AREA_W-1:0] areaType,
  input  logic              isWrite,
  input  logic [CNT_W-1:0]  waitCnt,
  input  logic              waitPinN,
  output logic              stall,
  output logic              cycDone
);
  logic      ctlRstN;
  logic      cntZero;
  logic      pinHold;
  ctlStrobeT strobes;

  assign ctlRstN = coldRstN & hotRstN;

  extWaitCtrl u_ctrl (
    .clk     (clk),
    .ctlRstN (ctlRstN),
    .cycStart(cycStart),
    .cntZero (cntZero),
    .pinHold (pinHold),
    .strobes (strobes),
    .stall   (stall),
    .cycDone (cycDone)
  );

  extWaitData #(
    .CNT_W(CNT_W), .AREA_W(AREA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_data (
    .clk        (clk),
    .coldRstN   (coldRstN),
    .ctlRstN    (ctlRstN),
    .cfgWr      (cfgWr),
    .cfgWaitEnIn(cfgWaitEnIn),
    .areaType   (areaType),
    .isWrite    (isWrite),
    .waitCnt    (waitCnt),
    .waitPinN   (waitPinN),
    .strobes    (strobes),
    .cntZero    (cntZero),
    .pinHold    (pinHold),
    .waitEn     (waitEnOut)
  );
endmodule

// File: rtl/extWaitCtl_chk.sv
module extWaitCtl_chk (
  input logic clk,
  input logic coldRstN,
  input logic hotRstN,
  input logic cfgWr,
  input logic cfgWaitEnIn,
  input logic waitEnOut,
  input logic cycStart,
  input logic stall,
  input logic cycDone
);
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!coldRstN || !hotRstN)
    !(stall && cycDone));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!coldRstN || !hotRstN)
    cycDone |=> !cycDone);

  a_r4_done_follows_stall: assert property (@(posedge clk) disable iff (!coldRstN || !hotRstN)
    $rose(cycDone) |-> $past(stall));

  a_r3_start_raises_stall: assert property (@(posedge clk) disable iff (!coldRstN || !hotRstN)
    (cycStart && !stall) |=> stall);

  a_r2_enable_write: assert property (@(posedge clk) disable iff (!coldRstN)
    cfgWr |=> (waitEnOut == $past(cfgWaitEnIn)));

  a_r2_enable_holds: assert property (@(posedge clk) disable iff (!coldRstN)
    !cfgWr |=> $stable(waitEnOut));

  a_r10_hot_clears: assert property (@(posedge clk) disable iff (!coldRstN)
    !hotRstN |-> (!stall && !cycDone));
endmodule

bind extWaitCtl extWaitCtl_chk u_chk (
  .clk        (clk),
  .coldRstN   (coldRstN),
  .hotRstN    (hotRstN),
  .cfgWr      (cfgWr),
  .cfgWaitEnIn(cfgWaitEnIn),
  .waitEnOut  (waitEnOut),
  .cycStart   (cycStart),
  .stall      (stall),
  .cycDone    (cycDone)
);

// File: tb/extWaitCtl_bench.sv
`timescale 1ns/1ps
module extWaitCtl_bench;
  logic clk = 1'b0;
  logic coldRstN = 1'b0, hotRstN = 1'b1;
  logic cfgWr = 1'b0, cfgWaitEnIn = 1'b0;
  logic cycStart = 1'b0, isWrite = 1'b0, waitPinN = 1'b1;
  logic [1:0] areaType = 2'b00;
  logic [2:0] waitCnt = 3'd0;
  logic waitEnOut, stall, cycDone;

  int tests = 0, fails = 0;
  string curReq = "R1";
  bit finished = 0;

  // behavioural reference state
  bit  mBusy = 0, mDone = 0, mEn = 0, mPinUse = 0;
  int  mRemain = 0;
  bit  pinHist[$];

  always #5 clk = ~clk;

  extWaitCtl u_extWaitCtl (
    .clk(clk), .coldRstN(coldRstN), .hotRstN(hotRstN),
    .cfgWr(cfgWr), .cfgWaitEnIn(cfgWaitEnIn), .waitEnOut(waitEnOut),
    .cycStart(cycStart), .areaType(areaType), .isWrite(isWrite),
    .waitCnt(waitCnt), .waitPinN(waitPinN),
    .stall(stall), .cycDone(cycDone)
  );

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic modelCtlReset();
    mBusy = 0; mDone = 0; mPinUse = 0; mRemain = 0;
    pinHist.delete(); pinHist.push_back(1'b1); pinHist.push_back(1'b1);
  endtask

  always @(negedge clk) begin
    if (!coldRstN || !hotRstN) pinHist.push_back(1'b1);
    else pinHist.push_back(waitPinN);
    if (pinHist.size() > 8) void'(pinHist.pop_front());
  end

  always @(posedge clk) begin
    bit syncv;
    if (coldRstN && hotRstN) begin
      syncv = pinHist[pinHist.size()-2];
      if (mBusy) begin
        if (mRemain > 0) begin mRemain--; mDone = 0; end
        else if (mPinUse && !syncv) mDone = 0;
        else begin mBusy = 0; mDone = 1; end
      end else begin
        mDone = 0;
        if (cycStart) begin
          mBusy = 1; mRemain = waitCnt;
          mPinUse = mEn && (areaType == 2'b01 || (areaType == 2'b10 && isWrite));
        end
      end
      if (cfgWr) mEn = cfgWaitEnIn;
    end
    #4;
    if (coldRstN && !finished) begin
      check(curReq, "stall vs model", stall, mBusy);
      check(curReq, "cycDone vs model", cycDone, mDone);
      check(curReq, "waitEnOut vs model", waitEnOut, mEn);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic writeEn(bit v);
    cfgWr = 1; cfgWaitEnIn = v; tick(); cfgWr = 0;
  endtask

  // start a cycle, release pin rel clocks after the accepting edge, return stall length
  task automatic runCycle(bit [1:0] kind, bit wr, int n, int rel, bit pinLow,
                          bit poke, output int len);
    areaType = kind; isWrite = wr; waitCnt = 3'(n);
    waitPinN = pinLow ? 1'b0 : 1'b1;
    cycStart = 1; tick(); cycStart = 0;
    len = 0;
    if (rel == 0) waitPinN = 1'b1;
    while (len < 100) begin
      if (poke && len == 0) begin cycStart = 1; waitCnt = 3'd7; end
      tick(); len++;
      cycStart = 0;
      if (len == rel) waitPinN = 1'b1;
      if (cycDone) break;
    end
    waitPinN = 1'b1;
    tick(2);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic int maxi(int a, int b);
    return (a > b) ? a : b;
  endfunction

  initial begin
    int len;
    modelCtlReset(); mEn = 0;
    tick(3);
    curReq = "R1";
    check("R1", "stall after cold reset", stall, 0);
    check("R1", "cycDone after cold reset", cycDone, 0);
    check("R1", "waitEnOut after cold reset", waitEnOut, 0);
    coldRstN = 1; tick(2);

    curReq = "R3";
    for (int n = 0; n < 8; n++) begin
      runCycle(2'b01, 0, n, 0, 0, 0, len);
      check("R3", "stall length count", len, n + 1);
    end

    curReq = "R8";
    runCycle(2'b01, 1, 2, 50, 1, 0, len);
    check("R8", "pin ignored when disabled", len, 3);

    curReq = "R2";
    writeEn(1);
    check("R2", "enable readback", waitEnOut, 1);
    tick(3);
    check("R2", "enable holds", waitEnOut, 1);

    curReq = "R5";
    runCycle(2'b01, 0, 1, 6, 1, 0, len);
    check("R5", "SRAM read extended by pin", len, maxi(2, 8));
    runCycle(2'b01, 1, 5, 3, 1, 0, len);
    check("R5", "count longer than pin hold", len, maxi(6, 5));
    runCycle(2'b01, 1, 0, 4, 1, 0, len);
    check("R5", "SRAM write, zero count", len, maxi(1, 6));

    curReq = "R6";
    runCycle(2'b10, 1, 2, 9, 1, 0, len);
    check("R6", "burst ROM write extended", len, maxi(3, 11));
    runCycle(2'b10, 0, 2, 40, 1, 0, len);
    check("R6", "burst ROM read ignores pin", len, 3);

    curReq = "R7";
    runCycle(2'b00, 1, 4, 40, 1, 0, len);
    check("R7", "type 00 ignores pin", len, 5);
    runCycle(2'b11, 0, 0, 40, 1, 0, len);
    check("R7", "type 11 ignores pin", len, 1);

    curReq = "R9";
    runCycle(2'b00, 0, 2, 40, 0, 1, len);
    check("R9", "start during stall ignored", len, 3);
    check("R9", "no second cycle", stall, 0);

    curReq = "R10";
    areaType = 2'b01; isWrite = 0; waitCnt = 3'd6; waitPinN = 0;
    cycStart = 1; tick(); cycStart = 0; tick(2);
    check("R10", "stall before hot reset", stall, 1);
    hotRstN = 0; modelCtlReset();
    tick(2);
    check("R10", "stall during hot reset", stall, 0);
    check("R10", "cycDone during hot reset", cycDone, 0);
    hotRstN = 1; waitPinN = 1; tick(2);
    check("R2", "enable kept through hot reset", waitEnOut, 1);
    check("R10", "idle after hot reset", stall, 0);

    curReq = "R8";
    writeEn(0);
    runCycle(2'b10, 1, 1, 30, 1, 0, len);
    check("R8", "burst ROM write, pin disabled", len, 2);

    curReq = "R1";
    coldRstN = 0; modelCtlReset(); mEn = 0;
    writeEn(1);
    check("R1", "cfgWr blocked in cold reset", waitEnOut, 0);
    coldRstN = 1; tick(2);
    check("R1", "enable cleared by cold reset", waitEnOut, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule